// File: doc/BRIEF.md
# Six-bit colour lookup table with VGA-DAC host protocol

This block is one palette group of a video splitter. It holds 256 colours, each with a 6-bit red, green and blue value. On the pixel side, an 8-bit index arrives every clock. The block ANDs that index with a pixel-mask register and, on the next clock, presents the 18-bit colour stored at the resulting entry. Software can rewrite the mask over and over to blink a display, for example through 0x3F, 0x7F, 0xBF and 0xFF. Three copies of the block serve three independent output lanes.

The host uses the familiar four-register DAC protocol: a pixel mask, a read-address register, a write-address register and a data port. The data port moves one colour component per access, in the order red, green, blue. The address advances after the blue access. A full palette load sets the write address to 0 and then streams 768 bytes into the data port. The host shifts 8-bit colours down by two bits before writing them, and shifts the 6-bit read-back values up again. Only the low six bits of each data byte matter.

Top module: `clut6_group`

## Requirements
- R1: After reset the mask reads 0xFF, both address registers read 0, the component phase is red, every entry holds zero and `pix_rgb` is zero.
- R2: Data-port writes collect red, then green, then blue. On the blue write, `{red,green,blue}` is stored at the write address and the write address increments, wrapping from 255 to 0.
- R3: One phase counter runs red → green → blue → red and is shared by data reads and data writes.
- R4: A data-port read returns the current component of the held triplet in bits 5:0, with bits 7:6 at zero. Reading blue increments the read address and reloads the triplet from the new entry.
- R5: Writing the write-address register (select 2) loads the address and resets the phase to red. Any half-written triplet is dropped.
- R6: Writing the read-address register (select 1) loads the address, captures that entry as the held triplet and resets the phase to red.
- R7: Bits 7:6 of data-port writes are ignored.
- R8: `pix_rgb` one clock after an index equals the entry at `pix_idx & mask`, packed as red in 17:12, green in 11:6 and blue in 5:0. Select 0 writes and reads the mask.
- R9: When a blue write and a pixel lookup address the same entry in one cycle, the pixel output shows the old colour. The new colour appears from the next lookup on.
- R10: `hst_rdata` is combinational. Select 0 returns the mask, select 1 the read address, select 2 the write address and select 3 the data component. A read strobe applied together with a write strobe is ignored.
- R11: After a write address of 0 and 768 data writes, all 256 entries are loaded and the write address is back at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe, one access per cycle |
| hst_rd | input | 1 | Host read strobe, advances the phase on data reads |
| hst_sel | input | 2 | Register select: 0 mask, 1 read address, 2 write address, 3 data |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data for the selected register |
| pix_idx | input | 8 | Pixel index |
| pix_rgb | output | 18 | Registered colour {r,g,b} |

## Verification
The embedded assertions check the protocol on every cycle: the phase encoding stays legal, the address registers load and reset the phase as required, the write and read addresses step after a blue access, and each committed triplet lands in its entry. The bench's scenarios are the only place that shows the end-to-end effects. These are the mask gating of pixel lookups across blink values, the old-value result on a same-entry collision, the dropping of a half-written triplet, wrap at entry 255, a full 768-byte load read back, and a read strobe ignored during a write. A behavioural model compares `hst_rdata` and `pix_rgb` on every clock.

// File: rtl/clut6_pkg.sv
package clut6_pkg;
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    localparam logic [1:0] SEL_MASK  = 2'd0;
    localparam logic [1:0] SEL_RADDR = 2'd1;
    localparam logic [1:0] SEL_WADDR = 2'd2;
    localparam logic [1:0] SEL_DATA  = 2'd3;
endpackage

// File: rtl/clut6_store.sv
module clut6_store #(
    parameter int IDX_W = 8,
    parameter int CH_W  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_addr,
    input  logic [3*CH_W-1:0]      wr_word,
    input  logic [IDX_W-1:0]       pix_addr,
    output logic [3*CH_W-1:0]      pix_word,
    input  logic [IDX_W-1:0]       host_addr,
    output logic [3*CH_W-1:0]      host_word
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int RGB_W = 3 * CH_W;

    logic [RGB_W-1:0] mem_q [DEPTH];

    // Reads see the array before this edge's write: collisions return the old colour.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_word;
        end
    end

    assign pix_word  = mem_q[pix_addr];
    assign host_word = mem_q[host_addr];

    // R2: a committed triplet is present in its entry on the following cycle
    p_commit_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_addr)] == $past(wr_word));
endmodule

// File: rtl/clut6_host.sv
module clut6_host
    import clut6_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CH_W  = 6,
    parameter int BUS_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hst_wr,
    input  logic                   hst_rd,
    input  logic [1:0]             hst_sel,
    input  logic [BUS_W-1:0]       hst_wdata,
    output logic [BUS_W-1:0]       hst_rdata,
    output logic [IDX_W-1:0]       look_addr,
    input  logic [3*CH_W-1:0]      look_word,
    output logic                   wr_en,
    output logic [IDX_W-1:0]       wr_addr,
    output logic [3*CH_W-1:0]      wr_word,
    output logic [IDX_W-1:0]       mask
);
    localparam int RGB_W = 3 * CH_W;

    typedef struct packed {
        logic [IDX_W-1:0] mask;
        logic [IDX_W-1:0] ra;
        logic [IDX_W-1:0] wa;
        phase_e           phase;
        logic [CH_W-1:0]  red;
        logic [CH_W-1:0]  grn;
        logic [RGB_W-1:0] trip;
    } host_s;

    host_s s_d, s_q;
    logic [CH_W-1:0] comp_in;
    logic [CH_W-1:0] comp_out;

    assign comp_in = hst_wdata[CH_W-1:0];

    always_comb begin
        s_d       = s_q;
        wr_en     = 1'b0;
        wr_word   = {s_q.red, s_q.grn, comp_in};
        look_addr = s_q.ra + 1'b1;
        if (hst_wr) begin
            case (hst_sel)
                SEL_MASK: s_d.mask = hst_wdata[IDX_W-1:0];
                SEL_RADDR: begin
                    s_d.ra    = hst_wdata[IDX_W-1:0];
                    look_addr = hst_wdata[IDX_W-1:0];
                    s_d.trip  = look_word;
                    s_d.phase = PH_RED;
                end
                SEL_WADDR: begin
                    s_d.wa    = hst_wdata[IDX_W-1:0];
                    s_d.phase = PH_RED;
                end
                default: begin
                    case (s_q.phase)
                        PH_RED: begin
                            s_d.red   = comp_in;
                            s_d.phase = PH_GRN;
                        end
                        PH_GRN: begin
                            s_d.grn   = comp_in;
                            s_d.phase = PH_BLU;
                        end
                        default: begin
                            wr_en     = 1'b1;
                            s_d.wa    = s_q.wa + 1'b1;
                            s_d.phase = PH_RED;
                        end
                    endcase
                end
            endcase
        end else if (hst_rd && hst_sel == SEL_DATA) begin
            case (s_q.phase)
                PH_RED:  s_d.phase = PH_GRN;
                PH_GRN:  s_d.phase = PH_BLU;
                default: begin
                    s_d.ra    = s_q.ra + 1'b1;
                    s_d.trip  = look_word;
                    s_d.phase = PH_RED;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.mask  <= '1;
            s_q.phase <= PH_RED;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (s_q.phase)
            PH_RED:  comp_out = s_q.trip[RGB_W-1 -: CH_W];
            PH_GRN:  comp_out = s_q.trip[2*CH_W-1 -: CH_W];
            default: comp_out = s_q.trip[CH_W-1:0];
        endcase
        hst_rdata = '0;
        case (hst_sel)
            SEL_MASK:  hst_rdata[IDX_W-1:0] = s_q.mask;
            SEL_RADDR: hst_rdata[IDX_W-1:0] = s_q.ra;
            SEL_WADDR: hst_rdata[IDX_W-1:0] = s_q.wa;
            default:   hst_rdata[CH_W-1:0]  = comp_out;
        endcase
    end

    assign wr_addr = s_q.wa;
    assign mask    = s_q.mask;

    // R3: the phase never takes the unused encoding
    p_phase_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.phase != 2'd3);

    // R5: write-address load restarts the triplet at red
    p_waddr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && hst_sel == SEL_WADDR) |=>
            (s_q.phase == PH_RED && s_q.wa == $past(hst_wdata[IDX_W-1:0])));

    // R6: read-address load restarts the triplet at red
    p_raddr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_wr && hst_sel == SEL_RADDR) |=>
            (s_q.phase == PH_RED && s_q.ra == $past(hst_wdata[IDX_W-1:0])));

    // R2: the blue write steps the write address
    p_wa_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> s_q.wa == $past(s_q.wa) + 1'b1);

    // R4: a blue data read steps the read address
    p_ra_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hst_wr && hst_rd && hst_sel == SEL_DATA && s_q.phase == PH_BLU) |=>
            s_q.ra == $past(s_q.ra) + 1'b1);
endmodule

// File: rtl/clut6_pixel.sv
module clut6_pixel #(
    parameter int IDX_W = 8,
    parameter int CH_W  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       pix_idx,
    input  logic [IDX_W-1:0]       mask,
    output logic [IDX_W-1:0]       look_addr,
    input  logic [3*CH_W-1:0]      look_word,
    output logic [3*CH_W-1:0]      pix_rgb
);
    localparam int RGB_W = 3 * CH_W;

    logic [RGB_W-1:0] rgb_d, rgb_q;

    always_comb begin
        look_addr = pix_idx & mask;
        rgb_d     = look_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rgb_q <= '0;
        else        rgb_q <= rgb_d;
    end

    assign pix_rgb = rgb_q;

    // R8: index bits cleared by the mask never reach the table
    p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (look_addr & ~mask) == '0);
endmodule

// File: rtl/clut6_group.sv
module clut6_group #(
    parameter int IDX_W = 8,
    parameter int CH_W  = 6,
    parameter int BUS_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hst_wr,
    input  logic                   hst_rd,
    input  logic [1:0]             hst_sel,
    input  logic [BUS_W-1:0]       hst_wdata,
    output logic [BUS_W-1:0]       hst_rdata,
    input  logic [IDX_W-1:0]       pix_idx,
    output logic [3*CH_W-1:0]      pix_rgb
);
    localparam int RGB_W = 3 * CH_W;

    logic [IDX_W-1:0] mask;
    logic [IDX_W-1:0] host_look_addr;
    logic [RGB_W-1:0] host_look_word;
    logic [IDX_W-1:0] pix_look_addr;
    logic [RGB_W-1:0] pix_look_word;
    logic             wr_en;
    logic [IDX_W-1:0] wr_addr;
    logic [RGB_W-1:0] wr_word;

    clut6_host #(.IDX_W(IDX_W), .CH_W(CH_W), .BUS_W(BUS_W)) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .hst_wr    (hst_wr),
        .hst_rd    (hst_rd),
        .hst_sel   (hst_sel),
        .hst_wdata (hst_wdata),
        .hst_rdata (hst_rdata),
        .look_addr (host_look_addr),
        .look_word (host_look_word),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_word   (wr_word),
        .mask      (mask)
    );

    clut6_store #(.IDX_W(IDX_W), .CH_W(CH_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_word   (wr_word),
        .pix_addr  (pix_look_addr),
        .pix_word  (pix_look_word),
        .host_addr (host_look_addr),
        .host_word (host_look_word)
    );

    clut6_pixel #(.IDX_W(IDX_W), .CH_W(CH_W)) u_pixel (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_idx   (pix_idx),
        .mask      (mask),
        .look_addr (pix_look_addr),
        .look_word (pix_look_word),
        .pix_rgb   (pix_rgb)
    );
endmodule

// File: tb/sim_clut6_group.sv
module sim_clut6_group;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr = 1'b0;
    logic        hst_rd = 1'b0;
    logic [1:0]  hst_sel = 2'd0;
    logic [7:0]  hst_wdata = 8'd0;
    logic [7:0]  hst_rdata;
    logic [7:0]  pix_idx = 8'd0;
    logic [17:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference state
    int m_mem [256];
    int m_mask, m_ra, m_wa, m_ph, m_r, m_g, m_pix;
    int m_trip [3];

    clut6_group u0 (
        .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_sel(hst_sel), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    always #5 clk = ~clk;

    function automatic int load_byte(int k);
        return (k * 29 + 7) & 255;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // model update on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_mem[i] = 0;
            m_mask = 255; m_ra = 0; m_wa = 0; m_ph = 0; m_r = 0; m_g = 0; m_pix = 0;
            for (int i = 0; i < 3; i++) m_trip[i] = 0;
        end else begin
            m_pix = m_mem[int'(pix_idx) & m_mask];
            if (hst_wr) begin
                case (hst_sel)
                    2'd0: m_mask = hst_wdata;
                    2'd1: begin
                        m_ra = hst_wdata; m_ph = 0;
                        m_trip[0] = (m_mem[m_ra] >> 12) & 63;
                        m_trip[1] = (m_mem[m_ra] >> 6) & 63;
                        m_trip[2] = m_mem[m_ra] & 63;
                    end
                    2'd2: begin m_wa = hst_wdata; m_ph = 0; end
                    default: begin
                        if (m_ph == 0) m_r = hst_wdata & 63;
                        else if (m_ph == 1) m_g = hst_wdata & 63;
                        else begin
                            m_mem[m_wa] = (m_r << 12) | (m_g << 6) | (hst_wdata & 63);
                            m_wa = (m_wa + 1) % 256;
                        end
                        m_ph = (m_ph + 1) % 3;
                    end
                endcase
            end else if (hst_rd && hst_sel == 2'd3) begin
                if (m_ph == 2) begin
                    m_ra = (m_ra + 1) % 256;
                    m_trip[0] = (m_mem[m_ra] >> 12) & 63;
                    m_trip[1] = (m_mem[m_ra] >> 6) & 63;
                    m_trip[2] = m_mem[m_ra] & 63;
                end
                m_ph = (m_ph + 1) % 3;
            end
        end
    end

    // per-cycle comparison, well away from the edges
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            int exp_rd;
            string tag;
            case (hst_sel)
                2'd0: begin exp_rd = m_mask; tag = "R8 mask read"; end
                2'd1: begin exp_rd = m_ra;   tag = "R6 read address"; end
                2'd2: begin exp_rd = m_wa;   tag = "R5 write address"; end
                default: begin exp_rd = m_trip[m_ph]; tag = "R4 data read"; end
            endcase
            check(tag, hst_rdata, exp_rd);
            check("R8 pixel colour", pix_rgb, m_pix);
        end
    end

    task automatic wr(logic [1:0] sel, int val);
        @(negedge clk);
        hst_wr = 1'b1; hst_rd = 1'b0; hst_sel = sel; hst_wdata = 8'(val);
    endtask

    task automatic idle();
        @(negedge clk);
        hst_wr = 1'b0; hst_rd = 1'b0; hst_sel = 2'd0;
    endtask

    task automatic rd(logic [1:0] sel, output int v);
        @(negedge clk);
        hst_wr = 1'b0; hst_rd = 1'b1; hst_sel = sel;
        #2 v = hst_rdata;
    endtask

    task automatic peek(logic [1:0] sel, output int v);
        @(negedge clk);
        hst_wr = 1'b0; hst_rd = 1'b0; hst_sel = sel;
        #2 v = hst_rdata;
    endtask

    initial begin
        int v;
        int e;
        repeat (3) @(negedge clk);
        #2;
        check("R1 reset pixel", pix_rgb, 0);
        check("R1 reset mask", hst_rdata, 8'hFF);
        rst_n = 1'b1;
        peek(2'd1, v); check("R1 reset read address", v, 0);
        peek(2'd2, v); check("R1 reset write address", v, 0);
        rd(2'd3, v);   check("R1 reset entry red", v, 0);

        // R11: full 768-byte load, some bytes with bits 7:6 set (R7)
        wr(2'd2, 0);
        for (int k = 0; k < 768; k++) wr(2'd3, load_byte(k));
        peek(2'd2, v); check("R11 write address back at 0", v, 0);

        // R6/R4: read back entries 5 and 6
        wr(2'd1, 5);
        for (int k = 0; k < 6; k++) begin
            rd(2'd3, v);
            check("R4 readback component", v, load_byte(15 + k) & 63);
        end
        peek(2'd1, v); check("R4 read address stepped twice", v, 7);

        // R8: pixel sweep under several blink masks
        for (int mi = 0; mi < 4; mi++) begin
            wr(2'd0, (mi * 64) + 63);
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                hst_wr = 1'b0; hst_sel = 2'd0; pix_idx = 8'(i * 53 + 11);
            end
        end
        wr(2'd0, 8'h3F);
        @(negedge clk); hst_wr = 1'b0; pix_idx = 8'hC5;
        @(negedge clk); #2;
        e = ((load_byte(15) & 63) << 12) | ((load_byte(16) & 63) << 6) | (load_byte(17) & 63);
        check("R8 mask 3F maps C5 to entry 05", pix_rgb, e);
        wr(2'd0, 8'hFF);

        // R9: same-entry collision returns old colour
        wr(2'd2, 10);
        wr(2'd3, 1); wr(2'd3, 2);
        pix_idx = 8'd10;
        wr(2'd3, 3);
        @(negedge clk); hst_wr = 1'b0; #2;
        e = ((load_byte(30) & 63) << 12) | ((load_byte(31) & 63) << 6) | (load_byte(32) & 63);
        check("R9 collision old colour", pix_rgb, e);
        @(negedge clk); #2;
        check("R9 new colour next lookup", pix_rgb, (1 << 12) | (2 << 6) | 3);

        // R7: upper bits ignored
        wr(2'd2, 40);
        wr(2'd3, 8'hC5); wr(2'd3, 8'h80); wr(2'd3, 8'h7F);
        wr(2'd1, 40);
        rd(2'd3, v); check("R7 red upper bits dropped", v, 5);
        rd(2'd3, v); check("R7 green upper bits dropped", v, 0);
        rd(2'd3, v); check("R7 blue upper bits dropped", v, 63);

        // R2: wrap from 255
        wr(2'd2, 255);
        wr(2'd3, 9); wr(2'd3, 8); wr(2'd3, 7);
        peek(2'd2, v); check("R2 write address wraps to 0", v, 0);

        // R5/R3: half triplet dropped by address reload
        wr(2'd2, 20);
        wr(2'd3, 33);
        wr(2'd2, 20);
        wr(2'd3, 4); wr(2'd3, 5); wr(2'd3, 6);
        wr(2'd1, 20);
        rd(2'd3, v); check("R5 red after phase reset", v, 4);
        rd(2'd3, v); check("R3 green", v, 5);
        rd(2'd3, v); check("R3 blue", v, 6);

        // R10: read strobe ignored during a write
        wr(2'd1, 20);
        @(negedge clk);
        hst_wr = 1'b1; hst_rd = 1'b1; hst_sel = 2'd0; hst_wdata = 8'hFF;
        rd(2'd3, v); check("R10 phase not advanced by overlapped read", v, 4);
        idle();
        idle();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule